// File: doc/BRIEF.md
# Set/Clear Output Port Register

This block holds an eight-bit output port register. A processor never writes the register as a whole. It changes the register through two dedicated write addresses, and each one takes a per-bit mask. A write to the set address forces to one every register bit whose data bit is one. A write to the clear address forces those bits to zero. Data bits of zero leave their register bits as they are. Because of this, software can change single pins without a read-modify-write sequence.

The pins show the complement of the stored value. A register value of 0x05 therefore appears as 0xFA on the pins. A separate configuration register is written as a whole at its own address. Each of its bits can move one pin away from its register bit and onto an auxiliary status input. The pins come from flops, so any change shows on the pins one clock edge after the register or configuration changes.

Top module: `outport_setclr`

## Requirements
- R1: While reset is asserted and after it is released, the register and the configuration register are 0x00, and all eight pins are 1 (0xFF).
- R2: A write (wr_en=1) to address 0xE sets every register bit whose wdata bit is 1 and leaves every other bit unchanged.
- R3: A write to address 0xF clears every register bit whose wdata bit is 1 and leaves every other bit unchanged. A mask of 0x00 changes nothing.
- R4: A pin whose configuration bit is 0 drives the inverse of its register bit (pin i = ~register bit i).
- R5: A pin whose configuration bit is 1 drives bit i of aux_in, sampled one cycle earlier.
- R6: The register keeps its value when wr_en is 0, whatever the address, and when a write goes to any address other than 0xE and 0xF.
- R7: The register changes on the clock edge at which the write strobe is sampled. The pins show the new value one edge later.
- R8: A write to address 0xD loads wdata as the configuration register, bit i for pin i. The pin selection follows on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| addr | input | 4 | Write address: 0xD configuration, 0xE set, 0xF clear |
| wdata | input | 8 | Write data or bit mask |
| aux_in | input | 8 | Auxiliary status signals, one per pin |
| pins | output | 8 | Output pins |

## Verification
A register bit that is set or cleared by mistake shows as a wrong level on a general-purpose pin two edges after the offending write. A mistake in the configuration register shows instead as a pin that follows aux_in when it should not, or fails to follow it. Both show within one cycle of the change that exposes them. The bench therefore keeps a behavioural model of the register, the configuration and the pin flops. It compares the pins on every cycle, over directed masks and over random traffic to all sixteen addresses, so a stuck or misdecoded bit is reported at the first cycle it becomes visible.

// File: rtl/outport_setclr.sv
module outport_setclr #(
  parameter int WIDTH = 8,
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 4'hD,
  parameter logic [ADDR_W-1:0] SET_ADDR = 4'hE,
  parameter logic [ADDR_W-1:0] CLR_ADDR = 4'hF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  input  logic [WIDTH-1:0]  aux_in,
  output logic [WIDTH-1:0]  pins
);

  logic [WIDTH-1:0] port_q;
  logic [WIDTH-1:0] sel_q;
  logic [WIDTH-1:0] pin_d;
  logic [WIDTH-1:0] pin_q;

  wire set_hit = wr_en && (addr == SET_ADDR);
  wire clr_hit = wr_en && (addr == CLR_ADDR);
  wire cfg_hit = wr_en && (addr == CFG_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       port_q <= '0;
    else if (set_hit) port_q <= port_q | wdata;
    else if (clr_hit) port_q <= port_q & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sel_q <= '0;
    else if (cfg_hit) sel_q <= wdata;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    assign pin_d[i] = sel_q[i] ? aux_in[i] : ~port_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= '1;
    else        pin_q <= pin_d;
  end

  assign pins = pin_q;

  // R1
  reset_pins_chk: assert property (@(posedge clk)
    !rst_n |-> (pins == {WIDTH{1'b1}}));

  // R2
  set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == SET_ADDR) |=>
      ((port_q & $past(wdata)) == $past(wdata)) &&
      ((port_q & ~$past(wdata)) == ($past(port_q) & ~$past(wdata))));

  // R3
  clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == CLR_ADDR) |=>
      ((port_q & $past(wdata)) == '0) &&
      ((port_q & ~$past(wdata)) == ($past(port_q) & ~$past(wdata))));

  // R6
  hold_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (addr == SET_ADDR || addr == CLR_ADDR)) |=> $stable(port_q));

  // R8
  cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == CFG_ADDR) |=> (sel_q == $past(wdata)));

  // R4 R7
  reg_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pins & ~$past(sel_q)) == (~$past(port_q) & ~$past(sel_q))));

  // R5
  aux_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pins & $past(sel_q)) == ($past(aux_in) & $past(sel_q))));

endmodule

// File: tb/outport_setclr_test.sv
module outport_setclr_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] aux_in = '0;
  logic [7:0] pins;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int m_reg = 0;
  int m_cfg = 0;
  int m_pins = 255;

  always #2.5 clk = ~clk;

  outport_setclr uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .aux_in(aux_in), .pins(pins)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_reg = 0; m_cfg = 0; m_pins = 255;
    end else begin
      m_pins = ((m_cfg & int'(aux_in)) | (~m_cfg & ~m_reg)) & 255;
      if (wr_en) begin
        if (addr == 4'hE) m_reg = m_reg | int'(wdata);
        else if (addr == 4'hF) m_reg = m_reg & ~int'(wdata) & 255;
        else if (addr == 4'hD) m_cfg = int'(wdata);
      end
    end
  end

  // per-cycle model comparison: R4 R5 R7
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (int'(pins) != m_pins) begin
        errors++;
        $display("FAIL R4 R5 R7 model: actual=%02h expected=%02h", pins, m_pins[7:0]);
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL R7 watchdog: actual=hung expected=done");
      finish_run();
    end
  end

  task automatic check(input string tag, input logic [7:0] exp);
    checks++;
    if (pins !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, pins, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  initial begin
    #1 rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 in reset", 8'hFF);
    rst_n = 1'b1;
    @(negedge clk); check("R1 after reset", 8'hFF);

    wr(4'hE, 8'h05);
    check("R7 pins lag register", 8'hFF);
    @(negedge clk); check("R2 R4 set 05", 8'hFA);
    wr(4'hE, 8'h30); @(negedge clk); check("R2 set 30 keeps 05", 8'hCA);
    wr(4'hF, 8'h01); @(negedge clk); check("R3 clear 01", 8'hCB);
    wr(4'hF, 8'h00); @(negedge clk); check("R3 empty clear mask", 8'hCB);
    wr(4'h3, 8'hFF); @(negedge clk); check("R6 other address", 8'hCB);
    @(negedge clk); wr_en = 1'b0; addr = 4'hF; wdata = 8'hFF;
    @(negedge clk); @(negedge clk); check("R6 strobe low", 8'hCB);

    aux_in = 8'hA5;
    wr(4'hD, 8'h0F);
    check("R8 selection lags config write", 8'hCB);
    @(negedge clk); check("R5 R8 lower nibble aux", 8'hC5);
    aux_in = 8'h3C;
    @(negedge clk); check("R5 aux follows", 8'hCC);
    wr(4'hF, 8'hFF); @(negedge clk); check("R3 clear all with aux", 8'hFC);
    wr(4'hD, 8'h00); @(negedge clk); check("R8 back to register", 8'hFF);
    wr(4'hE, 8'hFF); @(negedge clk); check("R2 set all", 8'h00);

    for (int n = 0; n < 600; n++) begin
      @(negedge clk);
      wr_en = ($urandom % 3) != 0;
      addr = 4'($urandom % 16);
      if (($urandom % 2) == 0) addr = 4'hC | 4'($urandom % 4);
      wdata = 8'($urandom);
      aux_in = 8'($urandom);
    end
    @(negedge clk); wr_en = 1'b0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule